// File: doc/BRIEF.md
# Signed Array Multiplier Without Sign Extension

This block multiplies two two's-complement operands and presents their full-width signed product with no clock and no state. Each bit of the first operand gates a copy of the second operand to make one partial-product row, and row `i` sits `i` columns to the left. The block does not sign-extend rows and does not subtract the last row. Instead it inverts a fixed set of matrix bits and adds two constant ones. A plain adder array can then add every row as if it were unsigned.

The array is a chain of ripple-carry row adders. Each adder is built from explicit half and full adder cells. The running sum passes down the chain, one row per adder, and the last sum is the product. The operand width is a parameter with a default of 8, which gives a 16-bit product. No state machine, clock or reset is needed. Any carry out of the top column is dropped.

Top module: `mulbw_array`

## Requirements
- R1: For every pair of signed operands, `product` equals their two's-complement product, taken over `2*WIDTH` bits.
- R2: Partial-product row `i` is formed by ANDing `op_a[i]` with each bit of `op_b`, and it is weighted by `2**i`. So for `op_a = 2**i` with `i < WIDTH-1`, `product` equals the sign-extended `op_b` shifted left by `i`.
- R3: If either operand is zero, `product` is zero.
- R4: The most negative value times itself gives `+2**(2*WIDTH-2)`. For width 8 this is -128 × -128 = 16384 (0x4000).
- R5: The most negative value times the most positive value gives the correct negative result. For width 8 this is -128 × 127 = -16256 (0xC080).
- R6: When both operands are nonzero, the top bit of `product` (bit `2*WIDTH-1`) is the XOR of the two operand top bits. Two negative operands give a positive result.
- R7: Multiplying by +1 returns the other operand sign-extended. Multiplying by -1 (all ones) returns its negation, so -128 × -1 = +128 (0x0080).
- R8: The constant ones and the complemented bits may carry past column `2*WIDTH-1`. That carry is dropped, and the output is exactly `2*WIDTH` bits wide. For example, -1 × -1 gives exactly 1.
- R9: The block is purely combinational. `product` follows an operand change with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH (8) | Signed multiplier operand; bit `i` gates row `i` |
| op_b | input | WIDTH (8) | Signed multiplicand operand; copied into every row |
| product | output | 2*WIDTH (16) | Signed product of the two operands |

## Verification
The bench targets the operand extremes, where the complement pattern is most likely to go wrong. A missing column constant or a wrong inversion on the last row shifts the result by a power of two, so -128 × -128 comes out negative or -128 × 127 is off by 2**15. Single-bit multipliers expose a row that is placed in the wrong column. The all-ones cases expose carry that leaks past the top column or a wrong negation. Every operand pair is swept, so an error confined to a single adder cell cannot go unnoticed.

// File: rtl/mulbw_pkg.sv
package mulbw_pkg;

    // Default operand width of the multiplier.
    parameter int unsigned MULBW_DEF_W = 8;

    // Complement rule for one matrix bit: the top bit of every ordinary row
    // is flipped, and every bit of the last row except its top bit is flipped.
    function automatic logic pp_flip(input int unsigned row, input int unsigned col,
                                     input int unsigned width);
        logic last_row;
        logic top_col;
        last_row = (row == width - 1);
        top_col  = (col == width - 1);
        return last_row ^ top_col;
    endfunction

endpackage

// File: rtl/mulbw_ha.sv
module mulbw_ha (
    input  logic x_in,
    input  logic y_in,
    output logic s_out,
    output logic c_out
);
    assign s_out = x_in ^ y_in;
    assign c_out = x_in & y_in;
endmodule

// File: rtl/mulbw_fa.sv
module mulbw_fa (
    input  logic x_in,
    input  logic y_in,
    input  logic c_in,
    output logic s_out,
    output logic c_out
);
    assign s_out = x_in ^ y_in ^ c_in;
    assign c_out = (x_in & y_in) | (c_in & (x_in ^ y_in));
endmodule

// File: rtl/mulbw_rowgen.sv
module mulbw_rowgen
    import mulbw_pkg::*;
#(
    parameter int unsigned WIDTH = MULBW_DEF_W
) (
    input  logic [WIDTH-1:0]                 op_a,
    input  logic [WIDTH-1:0]                 op_b,
    output logic [WIDTH-1:0][2*WIDTH-1:0]    rows_out
);
    localparam int unsigned PW = 2 * WIDTH;

    always_comb begin
        rows_out = '0;
        for (int r = 0; r < WIDTH; r++) begin
            for (int k = 0; k < WIDTH; k++) begin
                rows_out[r][r+k] = (op_a[r] & op_b[k])
                                   ^ pp_flip(r, k, WIDTH);
            end
        end
        // Two fixed ones: one just above row 0's top bit, one in the top column.
        rows_out[0][WIDTH] = 1'b1;
        rows_out[0][PW-1]  = 1'b1;
    end
endmodule

// File: rtl/mulbw_ripple.sv
module mulbw_ripple #(
    parameter int unsigned N = 16
) (
    input  logic [N-1:0] x_in,
    input  logic [N-1:0] y_in,
    output logic [N-1:0] sum_out
);
    // carry[k] is the carry produced by bit position k
    logic [N-2:0] carry;

    genvar k;
    generate
        for (k = 0; k < N; k++) begin : g_bit
            if (k == 0) begin : g_half
                mulbw_ha u_ha (
                    .x_in  (x_in[0]),
                    .y_in  (y_in[0]),
                    .s_out (sum_out[0]),
                    .c_out (carry[0])
                );
            end else if (k < N - 1) begin : g_full
                mulbw_fa u_fa (
                    .x_in  (x_in[k]),
                    .y_in  (y_in[k]),
                    .c_in  (carry[k-1]),
                    .s_out (sum_out[k]),
                    .c_out (carry[k])
                );
            end else begin : g_top
                // Top column: sum only; the carry out is dropped.
                assign sum_out[k] = x_in[k] ^ y_in[k] ^ carry[k-1];
            end
        end
    endgenerate
endmodule

// File: rtl/mulbw_array.sv
module mulbw_array
    import mulbw_pkg::*;
#(
    parameter int unsigned WIDTH = MULBW_DEF_W
) (
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    output logic [2*WIDTH-1:0] product
);
    localparam int unsigned PW = 2 * WIDTH;

    logic [WIDTH-1:0][PW-1:0] rows;
    logic [PW-1:0]            acc [WIDTH];

    mulbw_rowgen #(.WIDTH(WIDTH)) u_rowgen (
        .op_a     (op_a),
        .op_b     (op_b),
        .rows_out (rows)
    );

    assign acc[0] = rows[0];

    genvar i;
    generate
        for (i = 1; i < WIDTH; i++) begin : g_stage
            mulbw_ripple #(.N(PW)) u_add (
                .x_in    (acc[i-1]),
                .y_in    (rows[i]),
                .sum_out (acc[i])
            );
        end
    endgenerate

    assign product = acc[WIDTH-1];

    // Checks of the adder array's result against the operand ports.
    always_comb begin
        // R3: a zero operand forces a zero product
        if (op_a == '0 || op_b == '0)
            a_r3_zero_operand: assert (product == '0)
                else $error("R3 zero operand gave nonzero product");
        // R6: sign of a nonzero product
        if (op_a != '0 && op_b != '0)
            a_r6_sign: assert (product[PW-1] == (op_a[WIDTH-1] ^ op_b[WIDTH-1]))
                else $error("R6 product sign wrong");
        // R4: most negative value squared
        if (op_a == {1'b1, {(WIDTH-1){1'b0}}} && op_b == {1'b1, {(WIDTH-1){1'b0}}})
            a_r4_min_square: assert (product == {2'b01, {(PW-2){1'b0}}})
                else $error("R4 min squared wrong");
        // R7: multiply by +1 returns sign-extended operand
        if (op_b == {{(WIDTH-1){1'b0}}, 1'b1})
            a_r7_unit: assert (product == {{WIDTH{op_a[WIDTH-1]}}, op_a})
                else $error("R7 unit multiply wrong");
    end
endmodule

// File: tb/mulbw_array_test.sv
`timescale 1ns/1ps
module mulbw_array_test;
    localparam int W  = 8;
    localparam int PW = 2 * W;

    logic          clk = 1'b0;
    logic [W-1:0]  op_a = '0;
    logic [W-1:0]  op_b = '0;
    logic [PW-1:0] product;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    mulbw_array #(.WIDTH(W)) uut (
        .op_a    (op_a),
        .op_b    (op_b),
        .product (product)
    );

    function automatic logic [PW-1:0] ref_prod(input logic [W-1:0] x, input logic [W-1:0] y);
        int sx;
        int sy;
        sx = $signed(x);
        sy = $signed(y);
        return PW'(sx * sy);
    endfunction

    task automatic check(input string tag, input logic [PW-1:0] expv);
        checks++;
        if (product !== expv) begin
            errors++;
            $display("FAIL %s a=%0d b=%0d actual=%h expected=%h",
                     tag, $signed(op_a), $signed(op_b), product, expv);
        end
    endtask

    task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y,
                         input string tag, input logic [PW-1:0] expv);
        @(posedge clk);
        op_a = x;
        op_b = y;
        @(negedge clk);
        check(tag, expv);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000 && !done) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired");
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        // Reset state: zero operands give zero (R3)
        @(negedge clk);
        check("R3 idle", '0);

        // R4 / R5 extremes
        apply(8'h80, 8'h80, "R4", 16'h4000);
        apply(8'h80, 8'h7F, "R5", 16'hC080);
        apply(8'h7F, 8'h80, "R5 swapped", 16'hC080);
        apply(8'h7F, 8'h7F, "R1 max", 16'h3F01);

        // R3 zero with either side
        apply(8'h00, 8'h80, "R3 a zero", '0);
        apply(8'hB3, 8'h00, "R3 b zero", '0);

        // R7 unit and negative unit
        apply(8'h80, 8'h01, "R7 +1", 16'hFF80);
        apply(8'h80, 8'hFF, "R7 -1", 16'h0080);
        apply(8'h35, 8'hFF, "R7 -1 pos", 16'hFFCB);

        // R8 carry past the top column dropped
        apply(8'hFF, 8'hFF, "R8", 16'h0001);

        // R6 sign combinations
        apply(8'hF6, 8'hF9, "R6 neg*neg", 16'd70);
        apply(8'hF6, 8'h07, "R6 neg*pos", 16'hFFBA);

        // R2 single-bit multiplier places row i
        for (int i = 0; i < W - 1; i++) begin
            apply(8'(1 << i), 8'hA5, "R2 row",
                  PW'({{W{1'b1}}, 8'hA5} << i));
            apply(8'(1 << i), 8'h5A, "R2 row",
                  PW'({{W{1'b0}}, 8'h5A} << i));
        end

        // R9: change operands mid-cycle, sample with no clock edge
        @(negedge clk);
        op_a = 8'h0C;
        op_b = 8'hFD;
        #1;
        check("R9 comb", 16'hFFDC);

        // R1 random stimulus with a fixed seed
        begin
            int seed_v;
            seed_v = $urandom(32'h1D2C3B4A);
        end
        for (int n = 0; n < 20000; n++) begin
            logic [W-1:0] rx;
            logic [W-1:0] ry;
            rx = W'($urandom);
            ry = W'($urandom);
            apply(rx, ry, "R1 random", ref_prod(rx, ry));
        end

        // R1 exhaustive sweep
        for (int x = 0; x < (1 << W); x++) begin
            for (int y = 0; y < (1 << W); y++) begin
                apply(W'(x), W'(y), "R1 sweep", ref_prod(W'(x), W'(y)));
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule